// File: doc/BRIEF.md
# PWM Capture Timer

A general-purpose timer for a chip's peripheral subsystem. A 32-bit up-counter advances either on every system clock or on a selected edge of an external clock/gate pin. Two 32-bit compare registers can act as edge references for a PWM waveform or as capture latches.

In reference mode, the output rises when the counter reaches the high reference and falls when it reaches the low reference. The counter returns to zero after it reaches the low reference. Either match can set a sticky interrupt flag. In capture mode, the counter runs free: the high register follows the counter while the capture pin is high, and the low register follows it while the pin is low.

Software reaches the four registers through a plain word-indexed write port with a combinational read port. The external clock and capture pins are asynchronous. Each passes through a two-flop synchronizer in the system clock domain.

Top module: `pwm_capture_timer`

## Requirements
- R1: After reset all four registers read zero, and pwm_o, pwm_oe_o and irq_o are low. Register index 0 is the counter, 1 the high register, 2 the low register and 3 control.
- R2: The control bits are: 0 run, 1 external source, 2 falling edge, 3 one-shot, 4 interrupt enable, 5 output enable, 6 counter clear, 7 interrupt flag, 8 capture mode, 9 capture enable. With run set and external source clear, the counter gains one per clock. With run clear, it holds its value.
- R3: While the counter clear bit is set, the counter reads zero.
- R4: A write to index 0 loads the counter only when run is clear. With run set, the write is ignored.
- R5: With external source set and falling edge clear, the counter gains one per rising edge of ext_clk_i and ignores falling edges.
- R6: With external source and falling edge set, the counter gains one per falling edge of ext_clk_i and ignores rising edges.
- R7: In reference mode, a count event that finds the counter equal to the low register loads zero instead of incrementing.
- R8: With one-shot set, the same event also clears the run bit, so counting stops at zero.
- R9: In reference mode, a count event at the high value drives pwm_o high, and a count event at the low value drives it low. pwm_oe_o follows the output enable bit.
- R10: With interrupt enable set, a reference match sets the flag (control bit 7) and irq_o. The flag stays set until a control write with bit 7 at one clears it. Writing zero to bit 7 leaves it set.
- R11: With capture mode and capture enable set, the high register tracks the counter while cap_i is high, and the low register tracks it while cap_i is low. With capture enable clear, both keep their written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 2 | Register word index (byte offset / 4) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the indexed register (combinational) |
| ext_clk_i | input | 1 | External count clock or gate, asynchronous |
| cap_i | input | 1 | Capture level input, asynchronous |
| pwm_o | output | 1 | PWM waveform |
| pwm_oe_o | output | 1 | PWM output enable |
| irq_o | output | 1 | Interrupt request (sticky flag) |

## Verification
Every register write takes effect at the clock edge that samples the strobe. An internally clocked counter therefore advances at that same edge whenever run was already set, so a run of n idle cycles framed by two control writes yields n+1 counts. A change on ext_clk_i or cap_i reaches the counter or the capture registers at the third edge, after two synchronizer flops and one detection stage. The bench waits at least four cycles after such a change before it reads anything back. For the PWM and interrupt checks, the bench counts edges from the enabling write, then samples pwm_o and irq_o at the falling clock edge of the cycle in which the match result has been registered.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic cap_en;     // 9
    logic cap_mode;   // 8
    logic irq_flag;   // 7
    logic cnt_clr;    // 6
    logic oe;         // 5
    logic irq_en;     // 4
    logic one_shot;   // 3
    logic fall_edge;  // 2
    logic ext_src;    // 1
    logic run;        // 0
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int FLAG_BIT = 7;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_LOW  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ptc_sync.sv
module ptc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], async_i[g]};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= async_i[g];
      end
    end
    assign level_o[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ext_src_i,
  input  logic             fall_edge_i,
  input  logic             ext_lvl_i,
  input  logic             clr_i,
  input  logic             wrap_en_i,
  input  logic             one_shot_i,
  input  logic [CNT_W-1:0] wrap_val_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             shot_done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ext_prev_q;
  logic             ext_edge, at_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_prev_q <= 1'b0;
    else         ext_prev_q <= ext_lvl_i;
  end

  assign ext_edge = fall_edge_i ? (ext_prev_q & ~ext_lvl_i) : (~ext_prev_q & ext_lvl_i);
  assign tick_o   = run_i & (ext_src_i ? ext_edge : 1'b1);
  assign at_wrap  = wrap_en_i & (cnt_q == wrap_val_i);
  assign shot_done_o = tick_o & at_wrap & one_shot_i & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (wr_i && !run_i)  cnt_q <= wdata_i;
    else if (tick_o)          cnt_q <= at_wrap ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r3_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !run_i && !wr_i) |=> $stable(cnt_q));
  a_r7_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && wrap_en_i && (cnt_q == wrap_val_i) && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/ptc_ref_cap.sv
module ptc_ref_cap #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  input  logic             cap_mode_i,
  input  logic             cap_en_i,
  input  logic             cap_lvl_i,
  input  logic             wr_high_i,
  input  logic             wr_low_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] high_o,
  output logic [CNT_W-1:0] low_o,
  output logic             pwm_o,
  output logic             match_o
);
  logic [CNT_W-1:0] high_q, low_q;
  logic             pwm_q;
  logic             ref_evt, hit_high, hit_low, cap_active;

  assign ref_evt    = tick_i & ~cap_mode_i & ~clr_i;
  assign hit_high   = ref_evt & (cnt_i == high_q);
  assign hit_low    = ref_evt & (cnt_i == low_q);
  assign match_o    = hit_high | hit_low;
  assign cap_active = cap_mode_i & cap_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      high_q <= '0;
    else if (wr_high_i)               high_q <= wdata_i;
    else if (cap_active && cap_lvl_i) high_q <= cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       low_q <= '0;
    else if (wr_low_i)                 low_q <= wdata_i;
    else if (cap_active && !cap_lvl_i) low_q <= cnt_i;
  end

  // low match wins when both references are equal
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pwm_q <= 1'b0;
    else if (clr_i)    pwm_q <= 1'b0;
    else if (hit_low)  pwm_q <= 1'b0;
    else if (hit_high) pwm_q <= 1'b1;
  end

  assign high_o = high_q;
  assign low_o  = low_q;
  assign pwm_o  = pwm_q;

  a_r9_fall_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cap_mode_i && !clr_i && (cnt_i == low_q)) |=> !pwm_q);
  a_r9_rise_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cap_mode_i && !clr_i && (cnt_i == high_q) && (cnt_i != low_q)) |=> pwm_q);
  a_r11_high_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en_i && !wr_high_i) |=> $stable(high_q));
  a_r11_low_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en_i && !wr_low_i) |=> $stable(low_q));
endmodule

// File: rtl/pwm_capture_timer.sv
module pwm_capture_timer
  import ptc_pkg::*;
#(
  parameter int DW          = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_idx_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          ext_clk_i,
  input  logic          cap_i,
  output logic          pwm_o,
  output logic          pwm_oe_o,
  output logic          irq_o
);
  localparam int N_ASYNC = 2;

  ctrl_t         ctrl_q, ctrl_wr;
  reg_sel_e      sel;
  logic          wr_cnt, wr_high, wr_low, wr_ctrl;
  logic [N_ASYNC-1:0] lvl;
  logic [DW-1:0] cnt, high_v, low_v;
  logic          tick, shot_done, match;

  assign sel     = reg_sel_e'(reg_idx_i);
  assign wr_cnt  = reg_we_i & (sel == SEL_CNT);
  assign wr_high = reg_we_i & (sel == SEL_HIGH);
  assign wr_low  = reg_we_i & (sel == SEL_LOW);
  assign wr_ctrl = reg_we_i & (sel == SEL_CTRL);
  assign ctrl_wr = ctrl_t'(reg_wdata_i[CTRL_W-1:0]);

  ptc_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({cap_i, ext_clk_i}),
    .level_o (lvl)
  );

  ptc_counter #(.CNT_W(DW)) i_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (ctrl_q.run),
    .ext_src_i   (ctrl_q.ext_src),
    .fall_edge_i (ctrl_q.fall_edge),
    .ext_lvl_i   (lvl[0]),
    .clr_i       (ctrl_q.cnt_clr),
    .wrap_en_i   (~ctrl_q.cap_mode),
    .one_shot_i  (ctrl_q.one_shot),
    .wrap_val_i  (low_v),
    .wr_i        (wr_cnt),
    .wdata_i     (reg_wdata_i),
    .cnt_o       (cnt),
    .tick_o      (tick),
    .shot_done_o (shot_done)
  );

  ptc_ref_cap #(.CNT_W(DW)) i_ref_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .cnt_i      (cnt),
    .clr_i      (ctrl_q.cnt_clr),
    .cap_mode_i (ctrl_q.cap_mode),
    .cap_en_i   (ctrl_q.cap_en),
    .cap_lvl_i  (lvl[1]),
    .wr_high_i  (wr_high),
    .wr_low_i   (wr_low),
    .wdata_i    (reg_wdata_i),
    .high_o     (high_v),
    .low_o      (low_v),
    .pwm_o      (pwm_o),
    .match_o    (match)
  );

  // software write wins over one-shot stop; match set wins over W1C
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q          <= ctrl_wr;
        ctrl_q.irq_flag <= (ctrl_q.irq_flag & ~ctrl_wr.irq_flag) | (match & ctrl_q.irq_en);
      end else begin
        if (shot_done) ctrl_q.run <= 1'b0;
        if (match && ctrl_q.irq_en) ctrl_q.irq_flag <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CNT:  reg_rdata_o = cnt;
      SEL_HIGH: reg_rdata_o = high_v;
      SEL_LOW:  reg_rdata_o = low_v;
      default:  reg_rdata_o = {{(DW-CTRL_W){1'b0}}, ctrl_q};
    endcase
  end

  assign pwm_oe_o = ctrl_q.oe;
  assign irq_o    = ctrl_q.irq_flag;

  a_r8_shot_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shot_done && !wr_ctrl) |=> !ctrl_q.run);
  a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr_ctrl && reg_wdata_i[FLAG_BIT])) |=> irq_o);
  a_r10_flag_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !ctrl_q.irq_en && !wr_ctrl) |=> !irq_o);
endmodule

// File: tb/test_pwm_capture_timer.sv
`timescale 1ns/1ps
module test_pwm_capture_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_idx_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        ext_clk_i = 1'b0;
  logic        cap_i = 1'b0;
  logic        pwm_o, pwm_oe_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;  // 0 reg, 1 pwm, 2 oe, 3 irq
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk_i = ~clk_i;

  pwm_capture_timer i_pwm_capture_timer (
    .clk_i, .rst_ni, .reg_we_i, .reg_idx_i, .reg_wdata_i, .reg_rdata_o,
    .ext_clk_i, .cap_i, .pwm_o, .pwm_oe_o, .irq_o
  );

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = reg_rdata_o;
        1:       act = {31'd0, pwm_o};
        2:       act = {31'd0, pwm_oe_o};
        default: act = {31'd0, irq_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    reg_we_i = 1'b1; reg_idx_i = idx; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input int kind, input logic [1:0] idx, input logic [31:0] e, input string tag);
    item_t it;
    reg_idx_i = idx;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_i = 1'b1; cyc(4);
      ext_clk_i = 1'b0; cyc(4);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R1 reset state
    chk(0, 2'd0, 32'd0, "R1 counter");
    chk(0, 2'd1, 32'd0, "R1 high");
    chk(0, 2'd2, 32'd0, "R1 low");
    chk(0, 2'd3, 32'd0, "R1 ctrl");
    chk(1, 2'd0, 32'd0, "R1 pwm");
    chk(2, 2'd0, 32'd0, "R1 oe");
    chk(3, 2'd0, 32'd0, "R1 irq");

    // R4 load while stopped, R2 internal counting and hold
    wr(2'd2, 32'd1000);
    wr(2'd0, 32'h10);
    chk(0, 2'd0, 32'h10, "R4 load when stopped");
    wr(2'd0, 32'd0);
    wr(2'd3, 32'h1);
    cyc(6);
    wr(2'd3, 32'h0);
    chk(0, 2'd0, 32'd7, "R2 one per clock");
    cyc(3);
    chk(0, 2'd0, 32'd7, "R2 hold when stopped");

    // R4 write ignored while running
    wr(2'd0, 32'd0);
    wr(2'd3, 32'h1);
    wr(2'd0, 32'hABC);
    wr(2'd3, 32'h0);
    chk(0, 2'd0, 32'd2, "R4 ignored while running");

    // R3 clear bit
    wr(2'd3, 32'h41);
    cyc(4);
    chk(0, 2'd0, 32'd0, "R3 held at zero");
    wr(2'd3, 32'h0);

    // R5 rising external edges
    wr(2'd0, 32'd0);
    wr(2'd3, 32'h3);
    cyc(4);
    pulse(5);
    wr(2'd3, 32'h0);
    chk(0, 2'd0, 32'd5, "R5 rising edges");

    // R6 falling external edges
    wr(2'd0, 32'd0);
    wr(2'd3, 32'h7);
    cyc(4);
    pulse(3);
    ext_clk_i = 1'b1; cyc(4);
    wr(2'd3, 32'h0);
    chk(0, 2'd0, 32'd3, "R6 falling edges only");
    ext_clk_i = 1'b0; cyc(4);

    // R7 continuous wrap at low register
    wr(2'd2, 32'd4);
    wr(2'd0, 32'd0);
    wr(2'd3, 32'h1);
    cyc(6);
    wr(2'd3, 32'h0);
    chk(0, 2'd0, 32'd2, "R7 wrap modulo low+1");

    // R8 one-shot
    wr(2'd1, 32'd3);
    wr(2'd2, 32'd7);
    wr(2'd0, 32'd0);
    wr(2'd3, 32'h9);
    cyc(12);
    chk(0, 2'd0, 32'd0, "R8 stopped at zero");
    chk(0, 2'd3, 32'h8, "R8 run bit cleared");
    chk(1, 2'd0, 32'd0, "R9 low after one-shot");

    // R9 PWM edges, R10 interrupt
    wr(2'd0, 32'd0);
    wr(2'd3, 32'h31);
    cyc(5);
    chk(1, 2'd0, 32'd1, "R9 high after high match");
    chk(2, 2'd0, 32'd1, "R9 oe set");
    chk(3, 2'd0, 32'd1, "R10 irq on match");
    cyc(1);
    chk(1, 2'd0, 32'd0, "R9 low after low match");
    wr(2'd3, 32'h10);
    chk(3, 2'd0, 32'd1, "R10 flag kept on zero write");
    chk(0, 2'd3, 32'h90, "R10 flag readback");
    wr(2'd3, 32'h90);
    chk(3, 2'd0, 32'd0, "R10 flag cleared by one");
    chk(2, 2'd0, 32'd0, "R9 oe cleared");

    // R11 capture
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h77);
    cap_i = 1'b1; cyc(4);
    wr(2'd3, 32'h301);
    cyc(9);
    wr(2'd3, 32'h300);
    cyc(4);
    chk(0, 2'd0, 32'd10, "R11 counter stopped");
    chk(0, 2'd1, 32'd10, "R11 high captures on high");
    cap_i = 1'b0; cyc(4);
    chk(0, 2'd2, 32'd10, "R11 low captures on low");
    chk(0, 2'd1, 32'd10, "R11 high kept while low");
    wr(2'd3, 32'h100);
    wr(2'd1, 32'h55);
    cap_i = 1'b1; cyc(4);
    chk(0, 2'd1, 32'h55, "R11 capture disabled");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule